// File: doc/BRIEF.md
# Machine/Supervisor Interrupt CSR File

This block holds the control-and-status registers of a 32-bit processor that runs at machine and supervisor privilege. It keeps the status word, the interrupt-pending and interrupt-enable words, and, for each level, a trap vector, a cause, an exception PC, a bad-address (trap value) register and a scratch register. There is also an ISA description register. The supervisor status, pending and enable registers have no storage of their own. Each is a masked window onto the shared machine word. A read through the window returns only the bits inside the mask. A write through the window changes only those bits.

The core reaches the registers through one access port. The port takes a 12-bit CSR address, a read strobe, a write strobe and write data. Read data is combinational from the address. A write takes effect on the rising clock edge, so a read in the next cycle returns the new value. An access to an address that is not implemented raises an illegal-access flag and changes no register. The block also samples an external timer line into the machine timer pending bit. From that bit and the enables it drives a machine timer interrupt request toward the core.

Pending and enable share one bit layout. Software interrupts sit at bit 1 (supervisor) and bit 3 (machine). Timer interrupts sit at bit 5 (supervisor) and bit 7 (machine). External interrupts sit at bit 9 (supervisor) and bit 11 (machine).

Top module: `csr_file`

## Requirements
- R1: After reset, the following registers read 0: status (0x300), enable (0x304), pending (0x344), machine cause (0x342) and machine bad-address (0x343). The machine trap vector (0x305) reads 0x80000020, and timer_irq is low.
- R2: A write to a machine register replaces its whole 32-bit value. The machine registers are status 0x300, ISA 0x301, enable 0x304, trap vector 0x305, scratch 0x340, exception PC 0x341, cause 0x342, bad-address 0x343 and pending 0x344. The one exception is pending bit 7 (see R8). A read in the cycle after the write returns the new value.
- R3: A read of the supervisor status address 0x100 returns the machine status word ANDed with 0x133.
- R4: A read of the supervisor enable address 0x104 returns the enable word ANDed with 0x333. A read of the supervisor pending address 0x144 returns the pending word ANDed with 0x333.
- R5: A write to 0x100, 0x104 or 0x144 changes only the bits inside its mask. The mask is 0x133 for status and 0x333 for the other two. The result is new = (old & ~mask) | (wdata & mask), and it is visible at the machine address in the next cycle.
- R6: The supervisor trap vector (0x105), scratch (0x140), exception PC (0x141), cause (0x142) and trap value (0x143) are full 32-bit registers. Each is independent of the machine register at the same low offset.
- R7: Any read or write to an address outside the implemented set raises csr_illegal in the same cycle. It changes no register, and csr_rdata reads 0.
- R8: Every cycle, pending bit 7 takes the value of timer_line sampled at the clock edge. A software write to that bit is overridden.
- R9: timer_irq is high exactly when all three of these hold: the registered pending bit 7 is set, enable bit 7 is set, and status bit 3 is set. It therefore rises one cycle after timer_line rises, provided both enables are already set.
- R10: csr_illegal is low when no access is strobed. It is also low for every implemented address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_rd_en | input | 1 | Read strobe |
| csr_wr_en | input | 1 | Write strobe, applied at the rising edge |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| timer_line | input | 1 | External machine timer line |
| csr_rdata | output | 32 | Combinational read data for csr_addr |
| csr_illegal | output | 1 | Access to an unimplemented address |
| timer_irq | output | 1 | Machine timer interrupt request |

## Verification
All-ones and all-zeros words written through the supervisor windows show whether the masks are applied on read, on write, or on both. A reference model tracks every register and checks it against random sequences that mix machine writes, supervisor writes and unimplemented addresses. This tells masked merges apart from full replacement, and catches cross-coupling between the supervisor and machine copies of the trap registers. Writes to pending bit 7 that disagree with the timer line separate the hardware override from a software-owned bit. Toggling the timer line with each enable in turn shows the one-cycle latency of the interrupt and the three-way condition on it.

// File: rtl/csrf_pkg.sv
package csrf_pkg;

  localparam int NUM_ALIAS = 3;
  localparam int NUM_PLAIN = 11;
  localparam int NUM_CSR   = 2 * NUM_ALIAS + NUM_PLAIN;

  // alias slots: 0 status, 1 enable, 2 pending
  localparam int AL_STATUS = 0;
  localparam int AL_ENABLE = 1;
  localparam int AL_PEND   = 2;

  // plain register slots
  localparam int PL_MISA  = 0;
  localparam int PL_MTVEC = 1;

  localparam logic [31:0] STATUS_VIEW_MASK = 32'h0000_0133;
  localparam logic [31:0] INT_VIEW_MASK    = 32'h0000_0333;

  localparam int TIMER_PEND_BIT = 7;
  localparam int GLOBAL_IE_BIT  = 3;

  // Index order: machine alias views, supervisor alias views, plain registers
  function automatic logic [11:0] csr_addr_of(input int idx);
    case (idx)
      0:  csr_addr_of = 12'h300;
      1:  csr_addr_of = 12'h304;
      2:  csr_addr_of = 12'h344;
      3:  csr_addr_of = 12'h100;
      4:  csr_addr_of = 12'h104;
      5:  csr_addr_of = 12'h144;
      6:  csr_addr_of = 12'h301;
      7:  csr_addr_of = 12'h305;
      8:  csr_addr_of = 12'h340;
      9:  csr_addr_of = 12'h341;
      10: csr_addr_of = 12'h342;
      11: csr_addr_of = 12'h343;
      12: csr_addr_of = 12'h105;
      13: csr_addr_of = 12'h140;
      14: csr_addr_of = 12'h141;
      15: csr_addr_of = 12'h142;
      default: csr_addr_of = 12'h143;
    endcase
  endfunction

  function automatic logic [31:0] view_mask_of(input int slot);
    view_mask_of = (slot == AL_STATUS) ? STATUS_VIEW_MASK : INT_VIEW_MASK;
  endfunction

endpackage

// File: rtl/csrf_decode.sv
module csrf_decode #(
  parameter int ADDR_W = 12,
  parameter int N      = csrf_pkg::NUM_CSR
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    localparam logic [11:0] A = csrf_pkg::csr_addr_of(i);
    assign hit[i] = (addr == A[ADDR_W-1:0]);
  end
endmodule

// File: rtl/csrf_alias_reg.sv
module csrf_alias_reg #(
  parameter int         W         = 32,
  parameter logic [W-1:0] VIEW_MASK = '0,
  parameter logic [W-1:0] HW_MASK   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         full_we,
  input  logic         view_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_val,
  output logic [W-1:0] q
);
  logic [W-1:0] sw_next;

  always_comb begin
    sw_next = q;
    if (full_we)
      sw_next = wdata;
    else if (view_we)
      sw_next = (q & ~VIEW_MASK) | (wdata & VIEW_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (sw_next & ~HW_MASK) | (hw_val & HW_MASK);
  end
endmodule

// File: rtl/csrf_plain_bank.sv
module csrf_plain_bank #(
  parameter int           W           = 32,
  parameter int           N           = csrf_pkg::NUM_PLAIN,
  parameter logic [W-1:0] MTVEC_RESET = 32'h8000_0020,
  parameter logic [W-1:0] ISA_RESET   = 32'h4000_1100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [N-1:0]        sel,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam logic [W-1:0] RV = (i == csrf_pkg::PL_MTVEC) ? MTVEC_RESET :
                                  (i == csrf_pkg::PL_MISA)  ? ISA_RESET   : '0;
    always_ff @(posedge clk) begin
      if (rst)                q[i] <= RV;
      else if (we && sel[i])  q[i] <= wdata;
    end
  end
endmodule

// File: rtl/csr_file.sv
module csr_file #(
  parameter int              XLEN        = 32,
  parameter int              ADDR_W      = 12,
  parameter logic [XLEN-1:0] MTVEC_RESET = 32'h8000_0020,
  parameter logic [XLEN-1:0] ISA_RESET   = 32'h4000_1100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_rd_en,
  input  logic              csr_wr_en,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic              timer_line,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  output logic              timer_irq
);
  import csrf_pkg::*;

  localparam int SUP_BASE   = NUM_ALIAS;
  localparam int PLAIN_BASE = 2 * NUM_ALIAS;

  logic [NUM_CSR-1:0]              hit;
  logic [NUM_ALIAS-1:0][XLEN-1:0]  alias_q;
  logic [NUM_PLAIN-1:0][XLEN-1:0]  plain_q;
  logic [NUM_CSR-1:0][XLEN-1:0]    view_val;
  logic [XLEN-1:0]                 timer_hw;
  logic [XLEN-1:0]                 status_q, ie_q, ip_q, mtvec_q;

  csrf_decode #(.ADDR_W(ADDR_W), .N(NUM_CSR)) u_dec (
    .addr(csr_addr),
    .hit (hit)
  );

  assign timer_hw = XLEN'(timer_line) << TIMER_PEND_BIT;

  for (genvar a = 0; a < NUM_ALIAS; a++) begin : g_alias
    localparam logic [XLEN-1:0] HWM = (a == AL_PEND) ?
                                      (XLEN'(1) << TIMER_PEND_BIT) : '0;
    csrf_alias_reg #(
      .W        (XLEN),
      .VIEW_MASK(XLEN'(view_mask_of(a))),
      .HW_MASK  (HWM)
    ) u_reg (
      .clk    (clk),
      .rst    (rst),
      .full_we(csr_wr_en && hit[a]),
      .view_we(csr_wr_en && hit[SUP_BASE+a]),
      .wdata  (csr_wdata),
      .hw_val (timer_hw),
      .q      (alias_q[a])
    );
    assign view_val[a]          = alias_q[a];
    assign view_val[SUP_BASE+a] = alias_q[a] & XLEN'(view_mask_of(a));
  end

  csrf_plain_bank #(
    .W          (XLEN),
    .N          (NUM_PLAIN),
    .MTVEC_RESET(MTVEC_RESET),
    .ISA_RESET  (ISA_RESET)
  ) u_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (csr_wr_en),
    .sel  (hit[NUM_CSR-1:PLAIN_BASE]),
    .wdata(csr_wdata),
    .q    (plain_q)
  );

  for (genvar p = 0; p < NUM_PLAIN; p++) begin : g_pview
    assign view_val[PLAIN_BASE+p] = plain_q[p];
  end

  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < NUM_CSR; i++)
      if (hit[i]) csr_rdata = csr_rdata | view_val[i];
  end

  assign csr_illegal = (csr_rd_en || csr_wr_en) && !(|hit);

  assign status_q = alias_q[AL_STATUS];
  assign ie_q     = alias_q[AL_ENABLE];
  assign ip_q     = alias_q[AL_PEND];
  assign mtvec_q  = plain_q[PL_MTVEC];

  assign timer_irq = ip_q[TIMER_PEND_BIT] && ie_q[TIMER_PEND_BIT] &&
                     status_q[GLOBAL_IE_BIT];
endmodule

// File: rtl/csr_file_chk.sv
module csr_file_chk #(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_rd_en,
  input logic              csr_wr_en,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              csr_illegal,
  input logic              timer_line,
  input logic              timer_irq,
  input logic [XLEN-1:0]   status_q,
  input logic [XLEN-1:0]   ie_q,
  input logic [XLEN-1:0]   ip_q,
  input logic [XLEN-1:0]   mtvec_q
);
  localparam logic [XLEN-1:0] SMASK = XLEN'(32'h133);
  localparam logic [XLEN-1:0] IMASK = XLEN'(32'h333);

  // R7
  illegal_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr_en && csr_illegal) |=> ($stable(status_q) && $stable(ie_q) && $stable(mtvec_q)));

  // R7
  illegal_zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> (csr_rdata == '0));

  // R10
  illegal_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
    csr_illegal |-> (csr_rd_en || csr_wr_en));

  // R5
  status_view_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr_en && csr_addr == ADDR_W'(12'h100)) |=>
      ((status_q & ~SMASK) == ($past(status_q) & ~SMASK)));

  // R5
  enable_view_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr_en && csr_addr == ADDR_W'(12'h104)) |=>
      ((ie_q & ~IMASK) == ($past(ie_q) & ~IMASK)));

  // R4
  pend_view_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_rd_en && csr_addr == ADDR_W'(12'h144)) |-> ((csr_rdata & ~IMASK) == '0));

  // R6
  sup_vector_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr_en && csr_addr == ADDR_W'(12'h105)) |=> $stable(mtvec_q));

  // R8
  timer_pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ip_q[7] == $past(timer_line)));

  // R9
  irq_after_line_chk: assert property (@(posedge clk) disable iff (rst)
    timer_irq |-> $past(timer_line));
endmodule

bind csr_file csr_file_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .csr_rd_en  (csr_rd_en),
  .csr_wr_en  (csr_wr_en),
  .csr_addr   (csr_addr),
  .csr_rdata  (csr_rdata),
  .csr_illegal(csr_illegal),
  .timer_line (timer_line),
  .timer_irq  (timer_irq),
  .status_q   (status_q),
  .ie_q       (ie_q),
  .ip_q       (ip_q),
  .mtvec_q    (mtvec_q)
);

// File: tb/csr_file_test.sv
`timescale 1ns/1ps
module csr_file_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        rd, wr, tl;
  logic [11:0] addr;
  logic [31:0] wd;
  logic [31:0] rdata;
  logic        illegal, irq;

  int total = 0;
  int fails = 0;
  logic [31:0] last_rd;

  // reference model
  logic [31:0] m_st, m_ie, m_ip;
  logic [31:0] pl [0:10];

  always #2.5 clk = ~clk;

  csr_file uut (
    .clk(clk), .rst(rst), .csr_rd_en(rd), .csr_wr_en(wr), .csr_addr(addr),
    .csr_wdata(wd), .timer_line(tl), .csr_rdata(rdata),
    .csr_illegal(illegal), .timer_irq(irq)
  );

  function automatic int plain_idx(input logic [11:0] a);
    case (a)
      12'h301: return 0;  12'h305: return 1;  12'h340: return 2;
      12'h341: return 3;  12'h342: return 4;  12'h343: return 5;
      12'h105: return 6;  12'h140: return 7;  12'h141: return 8;
      12'h142: return 9;  12'h143: return 10;
      default: return -1;
    endcase
  endfunction

  function automatic bit implemented(input logic [11:0] a);
    return (a == 12'h300 || a == 12'h304 || a == 12'h344 || a == 12'h100 ||
            a == 12'h104 || a == 12'h144 || plain_idx(a) >= 0);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h300: return m_st;
      12'h304: return m_ie;
      12'h344: return m_ip;
      12'h100: return m_st & 32'h133;
      12'h104: return m_ie & 32'h333;
      12'h144: return m_ip & 32'h333;
      default: return (plain_idx(a) >= 0) ? pl[plain_idx(a)] : 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (a == 12'h100) return "R3";
    if (a == 12'h104 || a == 12'h144) return "R4";
    if (a == 12'h344) return "R8";
    if (a == 12'h105 || (a >= 12'h140 && a <= 12'h143)) return "R6";
    if (implemented(a)) return "R2";
    return "R7";
  endfunction

  task automatic model_reset();
    m_st = 0; m_ie = 0; m_ip = 0;
    for (int i = 0; i < 11; i++) pl[i] = 32'h0;
    pl[0] = 32'h4000_1100;
    pl[1] = 32'h8000_0020;
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h300: m_st = d;
      12'h304: m_ie = d;
      12'h344: m_ip = d;
      12'h100: m_st = (m_st & ~32'h133) | (d & 32'h133);
      12'h104: m_ie = (m_ie & ~32'h333) | (d & 32'h333);
      12'h144: m_ip = (m_ip & ~32'h333) | (d & 32'h333);
      default: if (plain_idx(a) >= 0) pl[plain_idx(a)] = d;
    endcase
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one access cycle: drive at negedge, check before the edge, update model after it
  task automatic step(input bit r, input bit w, input logic [11:0] a,
                      input logic [31:0] d, input bit t);
    bit exp_ill;
    @(negedge clk);
    rd = r; wr = w; addr = a; wd = d; tl = t;
    #1;
    exp_ill = (r || w) && !implemented(a);
    if (r) check(tag_of(a), "read data", rdata, exp_read(a));
    check(exp_ill ? "R7" : "R10", "illegal flag", {31'b0, illegal}, {31'b0, exp_ill});
    check("R9", "timer irq", {31'b0, irq},
          {31'b0, m_ip[7] & m_ie[7] & m_st[3]});
    last_rd = rdata;
    @(posedge clk);
    if (w && implemented(a)) model_write(a, d);
    m_ip[7] = t;
  endtask

  task automatic summary_and_end();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  initial begin
    logic [11:0] legal [0:16];
    void'($urandom(32'h5eed_1234));
    legal = '{12'h300, 12'h304, 12'h344, 12'h100, 12'h104, 12'h144, 12'h301,
              12'h305, 12'h340, 12'h341, 12'h342, 12'h343, 12'h105, 12'h140,
              12'h141, 12'h142, 12'h143};
    rst = 1'b1; rd = 0; wr = 0; addr = 0; wd = 0; tl = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset values
    step(1, 0, 12'h300, 0, 0); check("R1", "status reset", last_rd, 32'h0);
    step(1, 0, 12'h304, 0, 0); check("R1", "enable reset", last_rd, 32'h0);
    step(1, 0, 12'h344, 0, 0); check("R1", "pending reset", last_rd, 32'h0);
    step(1, 0, 12'h342, 0, 0); check("R1", "cause reset", last_rd, 32'h0);
    step(1, 0, 12'h343, 0, 0); check("R1", "bad-address reset", last_rd, 32'h0);
    step(1, 0, 12'h305, 0, 0); check("R1", "trap vector reset", last_rd, 32'h8000_0020);
    check("R1", "irq reset", {31'b0, irq}, 32'h0);

    // R2 / R3 full write then masked view
    step(0, 1, 12'h300, 32'hFFFF_FFFF, 0);
    step(1, 0, 12'h100, 0, 0); check("R3", "status view of ones", last_rd, 32'h133);
    step(1, 0, 12'h300, 0, 0); check("R2", "status full write", last_rd, 32'hFFFF_FFFF);
    // R5 masked write of zeros
    step(0, 1, 12'h100, 32'h0, 0);
    step(1, 0, 12'h300, 0, 0); check("R5", "status after view clear", last_rd, 32'hFFFF_FECC);
    step(0, 1, 12'h304, 32'hFFFF_FFFF, 0);
    step(1, 0, 12'h104, 0, 0); check("R4", "enable view of ones", last_rd, 32'h333);
    step(0, 1, 12'h104, 32'h0, 0);
    step(1, 0, 12'h304, 0, 0); check("R5", "enable after view clear", last_rd, 32'hFFFF_FCCC);
    step(0, 1, 12'h144, 32'hFFFF_FFFF, 0);
    step(1, 0, 12'h344, 0, 0); check("R5", "pending view set", last_rd, 32'h333);

    // R8 hardware override of pending bit 7
    step(0, 1, 12'h344, 32'h0, 1);
    step(1, 0, 12'h344, 0, 1); check("R8", "timer bit forced high", last_rd, 32'h80);
    step(0, 1, 12'h344, 32'h80, 0);
    step(1, 0, 12'h344, 0, 0); check("R8", "timer bit forced low", last_rd, 32'h0);

    // R9 irq conditions
    step(0, 1, 12'h300, 32'h8, 0);
    step(0, 1, 12'h304, 32'h80, 1);
    step(0, 0, 12'h000, 0, 1); check("R9", "irq raised", {31'b0, irq}, 32'h1);
    step(0, 1, 12'h300, 32'h0, 1);
    step(0, 0, 12'h000, 0, 1); check("R9", "irq off without global enable", {31'b0, irq}, 32'h0);
    step(0, 1, 12'h300, 32'h8, 0);
    step(0, 0, 12'h000, 0, 0); check("R9", "irq off with line low", {31'b0, irq}, 32'h0);

    // R6 independence of the supervisor trap registers
    step(0, 1, 12'h105, 32'h1234_5678, 0);
    step(1, 0, 12'h305, 0, 0); check("R6", "machine vector untouched", last_rd, 32'h8000_0020);
    step(1, 0, 12'h105, 0, 0); check("R6", "supervisor vector", last_rd, 32'h1234_5678);

    // R7 unimplemented write changes nothing
    step(0, 1, 12'h7C0, 32'hDEAD_BEEF, 0);
    step(1, 0, 12'h7C0, 0, 0); check("R7", "unimplemented read", last_rd, 32'h0);
    step(1, 0, 12'h300, 0, 0); check("R7", "status after bad write", last_rd, 32'h8);

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      bit r, w;
      a = ($urandom_range(0, 7) == 0) ? 12'($urandom) : legal[$urandom_range(0, 16)];
      r = $urandom_range(0, 1) == 1;
      w = $urandom_range(0, 2) == 0;
      step(r, w, a, $urandom, $urandom_range(0, 1) == 1);
    end

    summary_and_end();
  end
endmodule